// File: doc/BRIEF.md
# Automatic Flow-Control Character Injector

This block sits between a UART's transmit holding stage and its transmit shifter. It watches how full the local receive FIFO is and, on its own, sends software flow-control characters to the far end. When the FIFO count reaches the programmed trigger level, it sends a "stop" (Xoff) message. When the count falls back under that level, it sends a "go" (Xon) message. The block sends nothing else, so the far end sees one stop and one go for each trip across the threshold. A message is either one character or a pair of characters, chosen by a mode input. The character values come from the Xon/Xoff registers of the surrounding register file, where they reset to zero.

The injector holds the transmit path through a valid/ready handshake. The shifter raises `sh_ready` only between characters. While a flow-control sequence is active, the injector drives the character and blocks user data. When no sequence is active, user data passes straight through. The FSM has five states:

- `FC_IDLE`: pass-through.
- `FC_OFF1` and `FC_OFF2`: first and second stop character.
- `FC_ON1` and `FC_ON2`: first and second go character.

The transitions are:

- IDLE→OFF1 when the block is enabled, the level is high and no stop is outstanding.
- IDLE→ON1 when the block is enabled, the level is low and a stop is outstanding.
- OFF1→OFF2 and ON1→ON2 on accept in pair mode.
- OFF1/OFF2→IDLE and ON1/ON2→IDLE on accept of the last character of a message.

Top module: `xonxoff_injector`

## Requirements
- R1: After reset `peer_halted` is 0, no flow-control sequence is active, and with `usr_valid` low `tx_valid` is 0.
- R2: When the block is idle, `auto_en` is 1, `peer_halted` is 0 and `rx_level >= trig_level`, a stop message starts on the next clock edge. From then on `tx_valid` is 1 and `tx_data` is `stop_char1`.
- R3: `peer_halted` rises only on the clock edge where the last stop character is accepted (`tx_valid && sh_ready`). While it is 1, no further stop message is sent, however high the level goes.
- R4: A go message starts only when `peer_halted` is 1 and `rx_level < trig_level`. `peer_halted` falls only on the edge where the last go character is accepted.
- R5: With `dual_mode` 0 when a message starts, only the first character of the pair is sent (`stop_char1` or `go_char1`).
- R6: With `dual_mode` 1 when a message starts, the first and second characters are sent back to back in that order. The order is `stop_char1` then `stop_char2`, or `go_char1` then `go_char2`.
- R7: While a sequence is active, `usr_ready` is 0 and `tx_data` carries the flow-control character, even if `usr_valid` is 1.
- R8: A flow-control character presented with `sh_ready` low stays presented, with `tx_valid` 1 and `tx_data` unchanged, until it is accepted.
- R9: If the level drops under the trigger while a stop pair is still in progress, the pair completes first. The go pair follows, giving the order stop1, stop2, go1, go2.
- R10: While `auto_en` is 0, no new sequence starts.
- R11: When idle, `tx_valid` follows `usr_valid`, `tx_data` follows `usr_data`, and `usr_ready` follows `sh_ready`.
- R12: A level of `trig_level - 1` does not start a stop message, and a level equal to `trig_level` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic flow-control messages |
| dual_mode | input | 1 | 1: two-character messages, 0: one character |
| rx_level | input | CNT_W | Current receive FIFO fill count |
| trig_level | input | CNT_W | Trigger threshold |
| stop_char1 | input | CHAR_W | First stop (Xoff) character |
| stop_char2 | input | CHAR_W | Second stop (Xoff) character |
| go_char1 | input | CHAR_W | First go (Xon) character |
| go_char2 | input | CHAR_W | Second go (Xon) character |
| usr_valid | input | 1 | User holding-register data available |
| usr_data | input | CHAR_W | User holding-register data |
| usr_ready | output | 1 | User data taken by the shifter this cycle |
| tx_valid | output | 1 | Character offered to the shifter |
| tx_data | output | CHAR_W | Character offered to the shifter |
| sh_ready | input | 1 | Shifter idle between characters and accepting |
| peer_halted | output | 1 | A stop message has been sent and not yet cancelled |

## Verification
The bench builds the block with its defaults: CNT_W = 5 and CHAR_W = 8. With these widths, every level and threshold of a 16-deep FIFO is in range, and the bench uses a trigger of 8. The four characters are distinct 8-bit values, so any swap of pair order, any wrong register selection, and any leak of user data is visible in the accepted-character log. The bench holds `sh_ready` low during chosen cycles. This makes it possible to reach a level reversal in the middle of a pair, to check that a presented character is held, and to check that a waiting user character is blocked.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [2:0] {
        FC_IDLE = 3'd0,
        FC_OFF1 = 3'd1,
        FC_OFF2 = 3'd2,
        FC_ON1  = 3'd3,
        FC_ON2  = 3'd4
    } fc_state_e;

    typedef enum logic [1:0] {
        SEL_OFF1 = 2'd0,
        SEL_OFF2 = 2'd1,
        SEL_ON1  = 2'd2,
        SEL_ON2  = 2'd3
    } fc_sel_e;

    localparam int FC_NCHARS = 4;
endpackage

// File: rtl/fc_level_watch.sv
module fc_level_watch #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] trig_level,
    output logic             level_high
);
    // Level counts as high once it reaches the trigger.
    always_comb begin
        level_high = (rx_level >= trig_level);
    end
endmodule

// File: rtl/fc_seq_fsm.sv
module fc_seq_fsm
    import fc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    auto_en,
    input  logic    dual_mode,
    input  logic    level_high,
    input  logic    fc_accept,
    output logic    busy,
    output fc_sel_e sel,
    output logic    halted
);
    fc_state_e state_q, state_d;
    logic      pair_q, pair_d;
    logic      halted_d;
    logic      last_off, last_on;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_IDLE;
            pair_q  <= 1'b0;
            halted  <= 1'b0;
        end else begin
            state_q <= state_d;
            pair_q  <= pair_d;
            halted  <= halted_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pair_d  = pair_q;
        unique case (state_q)
            FC_IDLE: begin
                if (auto_en && level_high && !halted) begin
                    state_d = FC_OFF1;
                    pair_d  = dual_mode;
                end else if (auto_en && !level_high && halted) begin
                    state_d = FC_ON1;
                    pair_d  = dual_mode;
                end
            end
            FC_OFF1: if (fc_accept) state_d = pair_q ? FC_OFF2 : FC_IDLE;
            FC_OFF2: if (fc_accept) state_d = FC_IDLE;
            FC_ON1:  if (fc_accept) state_d = pair_q ? FC_ON2 : FC_IDLE;
            FC_ON2:  if (fc_accept) state_d = FC_IDLE;
            default: state_d = FC_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        busy     = 1'b1;
        sel      = SEL_OFF1;
        last_off = 1'b0;
        last_on  = 1'b0;
        unique case (state_q)
            FC_IDLE: busy = 1'b0;
            FC_OFF1: begin sel = SEL_OFF1; last_off = !pair_q; end
            FC_OFF2: begin sel = SEL_OFF2; last_off = 1'b1;    end
            FC_ON1:  begin sel = SEL_ON1;  last_on  = !pair_q; end
            FC_ON2:  begin sel = SEL_ON2;  last_on  = 1'b1;    end
            default: busy = 1'b0;
        endcase
        halted_d = halted;
        if (fc_accept && last_off) halted_d = 1'b1;
        if (fc_accept && last_on)  halted_d = 1'b0;
    end
endmodule

// File: rtl/fc_tx_arbiter.sv
module fc_tx_arbiter
    import fc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              busy,
    input  fc_sel_e           sel,
    input  logic [CHAR_W-1:0] stop_char1,
    input  logic [CHAR_W-1:0] stop_char2,
    input  logic [CHAR_W-1:0] go_char1,
    input  logic [CHAR_W-1:0] go_char2,
    input  logic              usr_valid,
    input  logic [CHAR_W-1:0] usr_data,
    input  logic              sh_ready,
    output logic              usr_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              fc_accept
);
    logic [CHAR_W-1:0] char_tab [FC_NCHARS];
    logic [CHAR_W-1:0] fc_char;

    assign char_tab[SEL_OFF1] = stop_char1;
    assign char_tab[SEL_OFF2] = stop_char2;
    assign char_tab[SEL_ON1]  = go_char1;
    assign char_tab[SEL_ON2]  = go_char2;

    always_comb begin
        fc_char = '0;
        for (int i = 0; i < FC_NCHARS; i++) begin
            if (sel == fc_sel_e'(i)) fc_char = char_tab[i];
        end
    end

    always_comb begin
        if (busy) begin
            tx_valid  = 1'b1;
            tx_data   = fc_char;
            usr_ready = 1'b0;
            fc_accept = sh_ready;
        end else begin
            tx_valid  = usr_valid;
            tx_data   = usr_data;
            usr_ready = sh_ready;
            fc_accept = 1'b0;
        end
    end
endmodule

// File: rtl/xonxoff_injector.sv
module xonxoff_injector
    import fc_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              dual_mode,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic [CHAR_W-1:0] stop_char1,
    input  logic [CHAR_W-1:0] stop_char2,
    input  logic [CHAR_W-1:0] go_char1,
    input  logic [CHAR_W-1:0] go_char2,
    input  logic              usr_valid,
    input  logic [CHAR_W-1:0] usr_data,
    output logic              usr_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              sh_ready,
    output logic              peer_halted
);
    logic    level_high;
    logic    seq_busy;
    logic    fc_accept;
    fc_sel_e seq_sel;

    fc_level_watch #(.CNT_W(CNT_W)) u_watch (
        .rx_level   (rx_level),
        .trig_level (trig_level),
        .level_high (level_high)
    );

    fc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .dual_mode  (dual_mode),
        .level_high (level_high),
        .fc_accept  (fc_accept),
        .busy       (seq_busy),
        .sel        (seq_sel),
        .halted     (peer_halted)
    );

    fc_tx_arbiter #(.CHAR_W(CHAR_W)) u_arb (
        .busy       (seq_busy),
        .sel        (seq_sel),
        .stop_char1 (stop_char1),
        .stop_char2 (stop_char2),
        .go_char1   (go_char1),
        .go_char2   (go_char2),
        .usr_valid  (usr_valid),
        .usr_data   (usr_data),
        .sh_ready   (sh_ready),
        .usr_ready  (usr_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .fc_accept  (fc_accept)
    );
endmodule

// File: rtl/fc_inject_chk.sv
module fc_inject_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_en,
    input logic              busy,
    input logic              usr_valid,
    input logic              usr_ready,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              sh_ready,
    input logic              peer_halted
);
    a_r8_hold_char: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sh_ready) |=> (tx_valid && $stable(tx_data)));

    a_r7_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!usr_ready && tx_valid));

    a_r3_halt_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(peer_halted) |-> $past(busy && sh_ready));

    a_r4_release_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(peer_halted) |-> $past(busy && sh_ready));

    a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !busy) |=> !busy);

    a_r11_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_valid == usr_valid && usr_ready == sh_ready));
endmodule

bind xonxoff_injector fc_inject_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .busy        (seq_busy),
    .usr_valid   (usr_valid),
    .usr_ready   (usr_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .sh_ready    (sh_ready),
    .peer_halted (peer_halted)
);

// File: tb/sim_xonxoff_injector.sv
`timescale 1ns/1ps
module sim_xonxoff_injector;
    localparam int CNT_W  = 5;
    localparam int CHAR_W = 8;
    localparam logic [7:0] S1 = 8'h13, S2 = 8'hA3, G1 = 8'h11, G2 = 8'hB1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_en = 1'b0, dual_mode = 1'b0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] trig_level = 5'd8;
    logic usr_valid = 1'b0;
    logic [CHAR_W-1:0] usr_data = '0;
    logic sh_ready = 1'b0;
    logic usr_ready, tx_valid, peer_halted;
    logic [CHAR_W-1:0] tx_data;

    int vectors = 0, miscompares = 0;
    logic done = 1'b0;

    logic [7:0] lg [0:31];
    int lg_n = 0;

    always #4 clk = ~clk;

    xonxoff_injector #(.CNT_W(CNT_W), .CHAR_W(CHAR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dual_mode(dual_mode),
        .rx_level(rx_level), .trig_level(trig_level),
        .stop_char1(S1), .stop_char2(S2), .go_char1(G1), .go_char2(G2),
        .usr_valid(usr_valid), .usr_data(usr_data), .usr_ready(usr_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .sh_ready(sh_ready),
        .peer_halted(peer_halted)
    );

    // Shifter model: log every accepted character.
    always @(posedge clk) begin
        if (rst_n && tx_valid && sh_ready && lg_n < 32) begin
            lg[lg_n] <= tx_data;
            lg_n <= lg_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 peer_halted", int'(peer_halted), 0);
        sh_ready = 1'b0; usr_valid = 1'b1; usr_data = 8'h5A;
        tick(1);
        chk("R11 tx_valid", int'(tx_valid), 1);
        chk("R11 tx_data", int'(tx_data), 8'h5A);
        chk("R11 usr_ready", int'(usr_ready), 0);
        sh_ready = 1'b1;
        #1;
        chk("R11 usr_ready follows", int'(usr_ready), 1);
        usr_valid = 1'b0; sh_ready = 1'b0;
        tick(1);
    endtask

    task automatic t_single_off;
        int base;
        auto_en = 1'b1; dual_mode = 1'b0; sh_ready = 1'b1;
        base = lg_n;
        rx_level = 5'd7;
        tick(4);
        chk("R12 no xoff below trigger", lg_n - base, 0);
        rx_level = 5'd8;
        tick(1);
        chk("R2 tx_valid after crossing", int'(tx_valid), 1);
        chk("R2 tx_data stop1", int'(tx_data), S1);
        tick(4);
        chk("R5 single xoff count", lg_n - base, 1);
        chk("R12 xoff at trigger", int'(lg[base]), S1);
        chk("R3 halted set", int'(peer_halted), 1);
        base = lg_n;
        rx_level = 5'd14;
        tick(6);
        chk("R3 no repeat xoff", lg_n - base, 0);
    endtask

    task automatic t_single_on;
        int base;
        base = lg_n;
        rx_level = 5'd3;
        tick(5);
        chk("R4 single xon count", lg_n - base, 1);
        chk("R5 xon char", int'(lg[base]), G1);
        chk("R4 halted cleared", int'(peer_halted), 0);
        base = lg_n;
        rx_level = 5'd1;
        tick(5);
        chk("R4 no xon without xoff", lg_n - base, 0);
    endtask

    task automatic t_dual_prio;
        int base;
        base = lg_n;
        dual_mode = 1'b1; sh_ready = 1'b0;
        usr_valid = 1'b1; usr_data = 8'h55;
        rx_level = 5'd9;
        tick(2);
        chk("R7 tx_data is stop1", int'(tx_data), S1);
        chk("R7 usr_ready blocked", int'(usr_ready), 0);
        tick(1);
        chk("R8 held valid", int'(tx_valid), 1);
        chk("R8 held data", int'(tx_data), S1);
        sh_ready = 1'b1;
        tick(1);
        chk("R6 second char presented", int'(tx_data), S2);
        chk("R7 usr still blocked", int'(usr_ready), 0);
        tick(1);
        chk("R7 user resumes", int'(tx_data), 8'h55);
        chk("R7 usr_ready back", int'(usr_ready), 1);
        usr_valid = 1'b0;
        chk("R6 dual xoff count", lg_n - base, 2);
        chk("R6 xoff order 1", int'(lg[base]), S1);
        chk("R6 xoff order 2", int'(lg[base+1]), S2);
        base = lg_n;
        rx_level = 5'd2;
        tick(6);
        chk("R6 dual xon count", lg_n - base, 2);
        chk("R6 xon order 1", int'(lg[base]), G1);
        chk("R6 xon order 2", int'(lg[base+1]), G2);
    endtask

    task automatic t_cross;
        int base;
        base = lg_n;
        dual_mode = 1'b1; sh_ready = 1'b0;
        rx_level = 5'd10;
        tick(2);
        rx_level = 5'd4;
        tick(2);
        sh_ready = 1'b1;
        tick(10);
        chk("R9 count", lg_n - base, 4);
        chk("R9 order 0", int'(lg[base]), S1);
        chk("R9 order 1", int'(lg[base+1]), S2);
        chk("R9 order 2", int'(lg[base+2]), G1);
        chk("R9 order 3", int'(lg[base+3]), G2);
        chk("R9 halted cleared", int'(peer_halted), 0);
    endtask

    task automatic t_disable;
        int base;
        base = lg_n;
        auto_en = 1'b0; dual_mode = 1'b0; sh_ready = 1'b1;
        rx_level = 5'd12;
        tick(6);
        chk("R10 nothing sent", lg_n - base, 0);
        chk("R10 not halted", int'(peer_halted), 0);
        auto_en = 1'b1;
        tick(5);
        chk("R10 sent after enable", lg_n - base, 1);
        chk("R10 char", int'(lg[base]), S1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_single_off();
        t_single_on();
        t_dual_prio();
        t_cross();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule